// File: doc/BRIEF.md
# Fractional-N Divider Register Commit Logic

This block holds the programming words for the main feedback divider of a fractional-N frequency synthesizer and decides the moment at which newly written values reach the divider. Software-side writes arrive as a stream of address/data beats. Each beat first lands in a staging register. Only the write that the current operating mode names as the committing one copies the staged words into the active registers that drive the divider and the modulator.

Three modes are supported: integer-N, fractional-N with a 16-bit fraction, and fractional-N with a 24-bit fraction. In integer-N mode a write to the integer word takes effect at once. In both fractional modes the low fractional word is the commit point: the integer word and, in 24-bit mode, the high fractional byte wait in staging until it arrives. Every commit can launch a one-cycle fastlock trigger. The charge-pump enable stays low after the synthesizer is powered until the first commit, so that the loop is not driven from an unprogrammed divider.

The write port is valid/ready. The block accepts one beat per cycle and never applies back-pressure: `wr_ready` is held high, and a beat is taken at every rising clock edge where `wr_valid` is high. Mode, synthesizer enable and fastlock enable are plain level inputs, sampled at the same edge as the beat.

Top module: `fracdiv_commit`

## Requirements
- R1: `wr_ready` is high in every cycle, including reset, and a beat is accepted at each rising edge with `wr_valid` high. `wr_addr` selects the target: 0 integer word, 1 low fractional word (`wr_data[15:0]`), 2 high fractional byte (`wr_data[7:0]`), 3 no register.
- R2: In integer-N mode (`mode` 0; the spare code 3 behaves the same), an accepted write to address 0 sets `act_int` to `wr_data[11:0]` and `act_frac` to zero. Both are visible in the cycle after the accepting edge.
- R3: In 16-bit fractional mode (`mode` 1), a write to address 0 changes only the staged integer. A write to address 1 commits: `act_int` takes the staged integer and `act_frac` becomes `{8'h00, wr_data[15:0]}`.
- R4: In 24-bit fractional mode (`mode` 2), writes to addresses 0 and 2 only stage. A write to address 1 commits: `act_int` takes the staged integer and `act_frac` becomes `{staged high byte, wr_data[15:0]}`.
- R5: Writes that are not the commit point for the current mode leave `act_int` and `act_frac` unchanged. These are address 1 in integer-N mode, address 2 in any mode, address 0 in a fractional mode, and address 3. The active values also hold in cycles with no write.
- R6: `stg_int` and `stg_frac` (`{high byte, low word}`) show the staged words from the cycle after the write. Address 3 changes neither.
- R7: `fastlock_pulse` is high for exactly the one cycle after each committing edge at which `fastlock_en` was high. It is low otherwise, including after commits made with `fastlock_en` low.
- R8: `cp_en` is low out of reset. It rises in the cycle after the first commit made at an edge where `pll_en` is high, and then stays high while `pll_en` stays high.
- R9: An edge with `pll_en` low forces `cp_en` low from the next cycle. After re-enabling, `cp_en` stays low until a new commit. Divider commits themselves still take effect while `pll_en` is low.
- R10: After reset, all active and staged values are zero and `fastlock_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always high; block accepts every beat |
| wr_addr | input | 2 | Target word: 0 integer, 1 fraction low, 2 fraction high, 3 none |
| wr_data | input | 16 | Write data |
| mode | input | 2 | 0 integer-N, 1 16-bit fraction, 2 24-bit fraction, 3 as 0 |
| pll_en | input | 1 | Synthesizer power enable |
| fastlock_en | input | 1 | Allow fastlock trigger on commit |
| act_int | output | 12 | Active integer divide value |
| act_frac | output | 24 | Active fractional divide value |
| stg_int | output | 12 | Staged integer word |
| stg_frac | output | 24 | Staged fraction, high byte over low word |
| fastlock_pulse | output | 1 | One-cycle fastlock trigger |
| cp_en | output | 1 | Charge-pump drive enable (low means high impedance) |

## Verification
Every result of this block is due exactly one cycle after the rising edge that accepts the beat or samples the level inputs. This covers the active words, the staged words, the fastlock pulse and the charge-pump enable. No output has any further latency. The driver applies each beat at a falling edge and, at the following rising edge, computes the expected outputs from the requirements and queues them. The monitor pops one item at the next falling edge and compares it, so each comparison falls exactly one edge after its cause. Idle cycles also queue an item, which confirms that the pulse drops and the active words hold.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

  typedef enum logic [1:0] {
    MODE_INTN = 2'd0,
    MODE_F16  = 2'd1,
    MODE_F24  = 2'd2,
    MODE_SPARE = 2'd3
  } div_mode_e;

  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_FLO  = 2'd1,
    SEL_FHI  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic is_integer_mode(input div_mode_e m);
    return (m == MODE_INTN) || (m == MODE_SPARE);
  endfunction

endpackage

// File: rtl/fracdiv_stage.sv
module fracdiv_stage
  import fracdiv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int INT_W  = 12,
  parameter int LO_W   = 16,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [INT_W-1:0]  stg_int,
  output logic [LO_W-1:0]   stg_lo,
  output logic [HI_W-1:0]   stg_hi
);

  localparam int NFIELD = 3;

  logic [NFIELD-1:0] field_we;

  always_comb begin
    field_we    = '0;
    field_we[0] = wr_en && (wr_sel == SEL_INT);
    field_we[1] = wr_en && (wr_sel == SEL_FLO);
    field_we[2] = wr_en && (wr_sel == SEL_FHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_int <= '0;
      stg_lo  <= '0;
      stg_hi  <= '0;
    end else begin
      if (field_we[0]) stg_int <= wr_data[INT_W-1:0];
      if (field_we[1]) stg_lo  <= wr_data[LO_W-1:0];
      if (field_we[2]) stg_hi  <= wr_data[HI_W-1:0];
    end
  end

endmodule

// File: rtl/fracdiv_commit_ctl.sv
module fracdiv_commit_ctl
  import fracdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_sel_e  wr_sel,
  input  div_mode_e mode,
  input  logic      pll_en,
  input  logic      fastlock_en,
  output logic      commit_int,
  output logic      commit_frac,
  output logic      fastlock_pulse,
  output logic      loaded
);

  logic int_mode;
  logic commit_any;

  always_comb begin
    int_mode    = is_integer_mode(mode);
    commit_int  = wr_en && (wr_sel == SEL_INT) && int_mode;
    commit_frac = wr_en && (wr_sel == SEL_FLO) && !int_mode;
    commit_any  = commit_int || commit_frac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fastlock_pulse <= 1'b0;
      loaded         <= 1'b0;
    end else begin
      fastlock_pulse <= commit_any && fastlock_en;
      if (!pll_en)
        loaded <= 1'b0;
      else if (commit_any)
        loaded <= 1'b1;
    end
  end

endmodule

// File: rtl/fracdiv_active.sv
module fracdiv_active
  import fracdiv_pkg::*;
#(
  parameter int INT_W = 12,
  parameter int LO_W  = 16,
  parameter int HI_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_int,
  input  logic                 commit_frac,
  input  div_mode_e            mode,
  input  logic [INT_W-1:0]     new_int,
  input  logic [INT_W-1:0]     stg_int,
  input  logic [HI_W-1:0]      stg_hi,
  input  logic [LO_W-1:0]      new_lo,
  output logic [INT_W-1:0]     act_int,
  output logic [LO_W+HI_W-1:0] act_frac
);

  localparam int FRAC_W = LO_W + HI_W;

  logic [HI_W-1:0] hi_apply;

  always_comb hi_apply = (mode == MODE_F24) ? stg_hi : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_int  <= '0;
      act_frac <= '0;
    end else if (commit_frac) begin
      act_int  <= stg_int;
      act_frac <= {hi_apply, new_lo};
    end else if (commit_int) begin
      act_int  <= new_int;
      act_frac <= {FRAC_W{1'b0}};
    end
  end

endmodule

// File: rtl/fracdiv_commit.sv
module fracdiv_commit
  import fracdiv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int INT_W  = 12,
  parameter int LO_W   = 16,
  parameter int HI_W   = 8,
  localparam int FRAC_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              pll_en,
  input  logic              fastlock_en,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic [INT_W-1:0]  stg_int,
  output logic [FRAC_W-1:0] stg_frac,
  output logic              fastlock_pulse,
  output logic              cp_en
);

  logic            wr_en;
  reg_sel_e        sel;
  div_mode_e       mode_e;
  logic [LO_W-1:0] stg_lo;
  logic [HI_W-1:0] stg_hi;
  logic            commit_int;
  logic            commit_frac;
  logic            loaded;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;
  assign sel      = reg_sel_e'(wr_addr);
  assign mode_e   = div_mode_e'(mode);
  assign stg_frac = {stg_hi, stg_lo};
  assign cp_en    = loaded;

  fracdiv_stage #(
    .DATA_W(DATA_W), .INT_W(INT_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
    .stg_int(stg_int), .stg_lo(stg_lo), .stg_hi(stg_hi)
  );

  fracdiv_commit_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .mode(mode_e),
    .pll_en(pll_en), .fastlock_en(fastlock_en),
    .commit_int(commit_int), .commit_frac(commit_frac),
    .fastlock_pulse(fastlock_pulse), .loaded(loaded)
  );

  fracdiv_active #(
    .INT_W(INT_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_active (
    .clk(clk), .rst_n(rst_n), .commit_int(commit_int), .commit_frac(commit_frac),
    .mode(mode_e), .new_int(wr_data[INT_W-1:0]), .stg_int(stg_int),
    .stg_hi(stg_hi), .new_lo(wr_data[LO_W-1:0]),
    .act_int(act_int), .act_frac(act_frac)
  );

endmodule

// File: rtl/fracdiv_commit_chk.sv
module fracdiv_commit_chk #(
  parameter int DATA_W = 16,
  parameter int INT_W  = 12,
  parameter int LO_W   = 16,
  parameter int HI_W   = 8,
  localparam int FRAC_W = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        mode,
  input logic              pll_en,
  input logic              fastlock_en,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac,
  input logic [INT_W-1:0]  stg_int,
  input logic [FRAC_W-1:0] stg_frac,
  input logic              fastlock_pulse,
  input logic              cp_en
);

  logic int_mode, w_int, w_lo, w_hi, cmt;
  assign int_mode = (mode == 2'd0) || (mode == 2'd3);
  assign w_int = wr_valid && (wr_addr == 2'd0);
  assign w_lo  = wr_valid && (wr_addr == 2'd1);
  assign w_hi  = wr_valid && (wr_addr == 2'd2);
  assign cmt   = (w_int && int_mode) || (w_lo && !int_mode);

  // R2
  int_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_int && int_mode) |-> (act_int == $past(wr_data[INT_W-1:0])) && (act_frac == '0));

  // R3
  f16_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_lo && mode == 2'd1) |->
      (act_int == $past(stg_int)) && (act_frac == {{HI_W{1'b0}}, $past(wr_data[LO_W-1:0])}));

  // R4
  f24_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_lo && mode == 2'd2) |->
      (act_int == $past(stg_int)) &&
      (act_frac == {$past(stg_frac[FRAC_W-1:LO_W]), $past(wr_data[LO_W-1:0])}));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmt) |-> $stable(act_int) && $stable(act_frac));

  // R5
  hibyte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_hi) |-> $stable(act_int) && $stable(act_frac));

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fastlock_pulse |-> $past(cmt && fastlock_en));

  // R7
  pulse_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmt && fastlock_en) |-> fastlock_pulse);

  // R8
  cp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_en) |-> $past(cmt && pll_en));

  // R9
  cp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pll_en) |-> !cp_en);

endmodule

bind fracdiv_commit fracdiv_commit_chk #(
  .DATA_W(DATA_W), .INT_W(INT_W), .LO_W(LO_W), .HI_W(HI_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode(mode), .pll_en(pll_en), .fastlock_en(fastlock_en),
  .act_int(act_int), .act_frac(act_frac), .stg_int(stg_int), .stg_frac(stg_frac),
  .fastlock_pulse(fastlock_pulse), .cp_en(cp_en)
);

// File: tb/fracdiv_commit_test.sv
module fracdiv_commit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode = '0;
  logic        pll_en = 1'b0;
  logic        fastlock_en = 1'b0;
  logic [11:0] act_int, stg_int;
  logic [23:0] act_frac, stg_frac;
  logic        fastlock_pulse, cp_en;

  always #2 clk = ~clk;

  fracdiv_commit uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode), .pll_en(pll_en),
    .fastlock_en(fastlock_en), .act_int(act_int), .act_frac(act_frac),
    .stg_int(stg_int), .stg_frac(stg_frac), .fastlock_pulse(fastlock_pulse),
    .cp_en(cp_en)
  );

  typedef struct {
    logic [11:0] ai;
    logic [23:0] af;
    logic [11:0] si;
    logic [23:0] sf;
    logic        p;
    logic        c;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  // bench model of the requirements
  logic [11:0] m_int = '0, s_int = '0;
  logic [23:0] m_frac = '0;
  logic [15:0] s_lo = '0;
  logic [7:0]  s_hi = '0;
  logic        m_cp = 1'b0;

  task automatic step(input logic v, input logic [1:0] a, input logic [15:0] d,
                      input logic [1:0] md, input logic pe, input logic fe,
                      input string tg);
    logic cmt;
    exp_t e;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; mode = md; pll_en = pe; fastlock_en = fe;
    @(posedge clk);
    cmt = 1'b0;
    if (v) begin
      case (a)
        2'd0: begin
          s_int = d[11:0];
          if (md == 2'd0 || md == 2'd3) begin m_int = d[11:0]; m_frac = '0; cmt = 1'b1; end
        end
        2'd1: begin
          s_lo = d;
          if (md == 2'd1 || md == 2'd2) begin
            m_int = s_int; m_frac = {(md == 2'd2) ? s_hi : 8'h00, d}; cmt = 1'b1;
          end
        end
        2'd2: s_hi = d[7:0];
        default: ;
      endcase
    end
    if (!pe) m_cp = 1'b0;
    else if (cmt) m_cp = 1'b1;
    e.ai = m_int; e.af = m_frac; e.si = s_int; e.sf = {s_hi, s_lo};
    e.p = cmt && fe; e.c = m_cp;
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  // monitor: compares one cycle after each accepting edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act_int !== e.ai || act_frac !== e.af || stg_int !== e.si ||
          stg_frac !== e.sf || fastlock_pulse !== e.p || cp_en !== e.c || wr_ready !== 1'b1) begin
        fails++;
        $display("FAIL %s: act=%h/%h stg=%h/%h pulse=%b cp=%b rdy=%b expected act=%h/%h stg=%h/%h pulse=%b cp=%b rdy=1",
                 t, act_int, act_frac, stg_int, stg_frac, fastlock_pulse, cp_en, wr_ready,
                 e.ai, e.af, e.si, e.sf, e.p, e.c);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 / R1 reset state
    checks++;
    if (act_int !== '0 || act_frac !== '0 || stg_int !== '0 || stg_frac !== '0 ||
        fastlock_pulse !== 1'b0 || cp_en !== 1'b0 || wr_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10: act=%h/%h stg=%h/%h pulse=%b cp=%b rdy=%b expected all zero, rdy=1",
               act_int, act_frac, stg_int, stg_frac, fastlock_pulse, cp_en, wr_ready);
    end
    rst_n = 1'b1;

    step(0, 0, 16'h0000, 0, 1, 1, "R8 enabled, not loaded");
    step(1, 0, 16'h014E, 0, 1, 1, "R2 integer commit with fastlock");
    step(0, 0, 16'h0000, 0, 1, 1, "R7 pulse ends");
    step(1, 1, 16'h1234, 0, 1, 1, "R5 low word in integer mode");
    step(1, 2, 16'h00C3, 0, 1, 1, "R5 high byte in integer mode");
    step(1, 3, 16'hFFFF, 0, 1, 1, "R6 address 3 ignored");
    step(1, 0, 16'h0064, 1, 1, 0, "R3 integer staged in 16-bit mode");
    step(1, 2, 16'h0077, 1, 1, 0, "R5 high byte staged in 16-bit mode");
    step(1, 1, 16'hABCD, 1, 1, 0, "R3 16-bit commit, hi forced zero, no pulse R7");
    step(1, 2, 16'h005A, 2, 1, 1, "R4 high byte staged");
    step(1, 0, 16'h00C8, 2, 1, 1, "R4 integer staged");
    step(1, 1, 16'h0001, 2, 1, 1, "R4 24-bit commit");
    step(1, 1, 16'h0002, 2, 1, 1, "R7 back-to-back commit pulse");
    step(1, 0, 16'h0007, 3, 1, 1, "R2 spare mode acts as integer");
    step(0, 0, 16'h0000, 3, 0, 0, "R9 disable drops cp_en");
    step(1, 0, 16'h0123, 0, 0, 1, "R9 commit while disabled");
    step(0, 0, 16'h0000, 0, 1, 0, "R9 re-enabled, still not loaded");
    step(1, 0, 16'h0F0F, 1, 1, 0, "R8 staged write does not load");
    step(1, 1, 16'h5555, 1, 1, 0, "R8 first commit after re-enable");
    step(0, 0, 16'h0000, 1, 1, 0, "R8 cp_en holds");
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule